// File: doc/BRIEF.md
# Super I/O Configuration Gate

This block guards the configuration space of a multi-function I/O controller. It sits on a byte-wide I/O bus and answers two neighbouring addresses: an even one that carries a register index and an odd one that carries register data. The configuration space stays locked until software writes a fixed entry key twice in a row to the index address. A fixed exit byte locks it again. While locked, the gate never changes configuration state.

Once open, the index picks a register. The lower part of the space (indices 0x00 to 0x2F) is one shared bank. Index 0x07 in that bank holds a device number, and that number routes every higher index to one of several per-device banks. Each per-device bank holds an activate register, three 16-bit base addresses, an interrupt number and type, and a DMA channel. The gate does not model the peripherals. It presents each device's configuration on output ports for the rest of the chip to use.

Top module: `sioCfgGate`

## Requirements
- R1: Two consecutive writes of 0x87 to the index address open the gate, and `cfgOpen` is high in the cycle after the second write.
- R2: While locked, any index-address write other than 0x87 (0xAA included) clears a partial key, so 0x87, 0x12, 0x87 leaves the gate locked. Data-address writes do not clear a partial key.
- R3: While open, writing 0xAA to the index address locks the gate and leaves the index unchanged. Any other value written to the index address becomes the new index.
- R4: While locked, data-address writes change no register, and reads of either address return 0xFF.
- R5: While open, a read of the data address returns the selected register and a read of the index address returns the index. `busRData` takes the value at the clock edge that samples `busRd` and holds it until the next read.
- R6: Indices 0x00 to 0x2F form a single shared bank whose contents do not depend on the selected device.
- R7: Register 0x07 holds the device number. Indices 0x30 and above address the bank of that device. If the number is NUM_DEV or higher, writes there are ignored and reads return 0x00.
- R8: Bit 0 of per-device register 0x30 drives `devActive[n]`, and writing 0x00 clears it.
- R9: Base address k (k = 0, 1, 2) takes its high byte at index 0x60+2k and its low byte at 0x61+2k. It appears at `devBase[(n*3+k)*16 +: 16]`.
- R10: Per-device register 0x70 drives `devIrq[n*8 +: 8]`, and register 0x71 (0x02 = active-high edge) drives `devIrqType[n*8 +: 8]`.
- R11: For per-device register 0x74, bit 2 set (value 0x04) means no DMA: `devDmaEn[n]` is the inverse of bit 2, and `devDmaChan[n*2 +: 2]` is bits 1:0.
- R12: A per-device index that is not one of the defined registers (for example 0x40) ignores writes and reads 0x00.
- R13: After reset the gate is locked, every device is inactive, and every register, including the index, is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | I/O bus address |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Registered read data |
| cfgOpen | output | 1 | Configuration space unlocked |
| devActive | output | NUM_DEV | Per-device activate bit |
| devBase | output | NUM_DEV*NUM_BASE*16 | Per-device base addresses |
| devIrq | output | NUM_DEV*8 | Per-device interrupt number |
| devIrqType | output | NUM_DEV*8 | Per-device interrupt type |
| devDmaEn | output | NUM_DEV | Per-device DMA enabled |
| devDmaChan | output | NUM_DEV*2 | Per-device DMA channel |

## Verification
The bench sends a broken key (0x87, another byte, then 0x87) and checks that the gate stays locked. A design that counted entry bytes without requiring them to be consecutive would open at this point. It writes to the data address while locked and later reads the same register back, which exposes a gate that lets writes through. It switches between devices, and to a device number beyond the last bank, to confirm that per-device registers are banked and that the shared bank is not. It also closes the gate with the index parked on the activate register and reads that register after reopening. A design that overwrote the index with the exit byte would return the wrong register here.

// File: rtl/sioCfgPkg.sv
package sioCfgPkg;

  typedef enum logic [1:0] {
    GATE_LOCKED,
    GATE_HALF,
    GATE_OPEN
  } gateState_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_FF,
    RD_IDX,
    RD_REG
  } rdKind_t;

  typedef struct packed {
    logic       wrStb;
    logic [7:0] idx;
    logic [7:0] wData;
    rdKind_t    rdKind;
  } cfgStrobe_t;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] GLOBAL_TOP  = 8'h30;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE    = 8'h60;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_IRQTYPE = 8'h71;
  localparam logic [7:0] IDX_DMA     = 8'h74;

endpackage

// File: rtl/sioCfgCtrl.sv
module sioCfgCtrl
  import sioCfgPkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h370
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWData,
  output logic              cfgOpen,
  output cfgStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = {BASE_ADDR[ADDR_W-1:1], 1'b0};
  localparam logic [ADDR_W-1:0] DAT_ADDR = {BASE_ADDR[ADDR_W-1:1], 1'b1};

  gateState_t state;
  logic [7:0] idxReg;
  logic       hitIdx;
  logic       hitDat;

  assign hitIdx  = (busAddr == IDX_ADDR);
  assign hitDat  = (busAddr == DAT_ADDR);
  assign cfgOpen = (state == GATE_OPEN);

  // key sequencer and index register
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= GATE_LOCKED;
      idxReg <= '0;
    end else if (busWr && hitIdx) begin
      unique case (state)
        GATE_OPEN: begin
          if (busWData == KEY_EXIT) state <= GATE_LOCKED;
          else idxReg <= busWData;
        end
        GATE_HALF:
          state <= (busWData == KEY_ENTER) ? GATE_OPEN : GATE_LOCKED;
        default:
          state <= (busWData == KEY_ENTER) ? GATE_HALF : GATE_LOCKED;
      endcase
    end
  end

  always_comb begin
    strobe.wrStb  = busWr && hitDat && cfgOpen;
    strobe.idx    = idxReg;
    strobe.wData  = busWData;
    strobe.rdKind = RD_NONE;
    if (busRd && (hitIdx || hitDat)) begin
      if (!cfgOpen) strobe.rdKind = RD_FF;
      else if (hitDat) strobe.rdKind = RD_REG;
      else strobe.rdKind = RD_IDX;
    end
  end

endmodule

// File: rtl/sioCfgRegs.sv
module sioCfgRegs
  import sioCfgPkg::*;
#(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned NUM_BASE = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cfgStrobe_t                 strobe,
  output logic [7:0]                 busRData,
  output logic [NUM_DEV-1:0]         devActive,
  output logic [NUM_DEV*NUM_BASE*16-1:0] devBase,
  output logic [NUM_DEV*8-1:0]       devIrq,
  output logic [NUM_DEV*8-1:0]       devIrqType,
  output logic [NUM_DEV-1:0]         devDmaEn,
  output logic [NUM_DEV*2-1:0]       devDmaChan
);

  localparam int unsigned NUM_GLOBAL = 48;
  localparam int unsigned SEL_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int unsigned BASE_BYTES = 2 * NUM_BASE;
  localparam int unsigned BS_W       = (BASE_BYTES > 1) ? $clog2(BASE_BYTES) : 1;
  localparam logic [7:0]  BASE_END   = 8'(IDX_BASE + BASE_BYTES);
  localparam logic [7:0]  DEV_LIMIT  = 8'(NUM_DEV);

  logic [7:0] globReg    [NUM_GLOBAL];
  logic [7:0] actReg     [NUM_DEV];
  logic [7:0] baseReg    [NUM_DEV][BASE_BYTES];
  logic [7:0] irqReg     [NUM_DEV];
  logic [7:0] irqTypeReg [NUM_DEV];
  logic [7:0] dmaReg     [NUM_DEV];

  logic [7:0]      devSel;
  logic            devSelOk;
  logic [SEL_W-1:0] selIdx;
  logic            isGlobal;
  logic            isBase;
  logic [7:0]      baseOff;
  logic [BS_W-1:0] baseSlot;
  logic [7:0]      rdVal;

  assign devSel   = globReg[IDX_DEVSEL[5:0]];
  assign devSelOk = (devSel < DEV_LIMIT);
  assign selIdx   = devSel[SEL_W-1:0];
  assign isGlobal = (strobe.idx < GLOBAL_TOP);
  assign isBase   = (strobe.idx >= IDX_BASE) && (strobe.idx < BASE_END);
  assign baseOff  = strobe.idx - IDX_BASE;
  assign baseSlot = baseOff[BS_W-1:0];

  // read mux for the selected register
  always_comb begin
    rdVal = '0;
    if (isGlobal) begin
      rdVal = globReg[strobe.idx[5:0]];
    end else if (devSelOk) begin
      if (strobe.idx == IDX_ACT)          rdVal = actReg[selIdx];
      else if (isBase)                    rdVal = baseReg[selIdx][baseSlot];
      else if (strobe.idx == IDX_IRQ)     rdVal = irqReg[selIdx];
      else if (strobe.idx == IDX_IRQTYPE) rdVal = irqTypeReg[selIdx];
      else if (strobe.idx == IDX_DMA)     rdVal = dmaReg[selIdx];
    end
  end

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_GLOBAL; g++) globReg[g] <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        actReg[d]     <= '0;
        irqReg[d]     <= '0;
        irqTypeReg[d] <= '0;
        dmaReg[d]     <= '0;
        for (int b = 0; b < BASE_BYTES; b++) baseReg[d][b] <= '0;
      end
    end else if (strobe.wrStb) begin
      if (isGlobal) begin
        globReg[strobe.idx[5:0]] <= strobe.wData;
      end else if (devSelOk) begin
        if (strobe.idx == IDX_ACT)          actReg[selIdx] <= strobe.wData;
        else if (isBase)                    baseReg[selIdx][baseSlot] <= strobe.wData;
        else if (strobe.idx == IDX_IRQ)     irqReg[selIdx] <= strobe.wData;
        else if (strobe.idx == IDX_IRQTYPE) irqTypeReg[selIdx] <= strobe.wData;
        else if (strobe.idx == IDX_DMA)     dmaReg[selIdx] <= strobe.wData;
      end
    end
  end

  // read data register
  always_ff @(posedge clk) begin
    if (rst) begin
      busRData <= '0;
    end else begin
      unique case (strobe.rdKind)
        RD_FF:   busRData <= 8'hFF;
        RD_IDX:  busRData <= strobe.idx;
        RD_REG:  busRData <= rdVal;
        default: busRData <= busRData;
      endcase
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign devActive[d]          = actReg[d][0];
    assign devIrq[d*8 +: 8]      = irqReg[d];
    assign devIrqType[d*8 +: 8]  = irqTypeReg[d];
    assign devDmaEn[d]           = ~dmaReg[d][2];
    assign devDmaChan[d*2 +: 2]  = dmaReg[d][1:0];
    for (genvar k = 0; k < NUM_BASE; k++) begin : g_base
      assign devBase[(d*NUM_BASE+k)*16 +: 16] = {baseReg[d][2*k], baseReg[d][2*k+1]};
    end
  end

endmodule

// File: rtl/sioCfgGate.sv
module sioCfgGate
  import sioCfgPkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h370,
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned NUM_BASE = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWr,
  input  logic                           busRd,
  input  logic [7:0]                     busWData,
  output logic [7:0]                     busRData,
  output logic                           cfgOpen,
  output logic [NUM_DEV-1:0]             devActive,
  output logic [NUM_DEV*NUM_BASE*16-1:0] devBase,
  output logic [NUM_DEV*8-1:0]           devIrq,
  output logic [NUM_DEV*8-1:0]           devIrqType,
  output logic [NUM_DEV-1:0]             devDmaEn,
  output logic [NUM_DEV*2-1:0]           devDmaChan
);

  cfgStrobe_t strobe;

  sioCfgCtrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWData (busWData),
    .cfgOpen  (cfgOpen),
    .strobe   (strobe)
  );

  sioCfgRegs #(
    .NUM_DEV  (NUM_DEV),
    .NUM_BASE (NUM_BASE)
  ) regs_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .busRData   (busRData),
    .devActive  (devActive),
    .devBase    (devBase),
    .devIrq     (devIrq),
    .devIrqType (devIrqType),
    .devDmaEn   (devDmaEn),
    .devDmaChan (devDmaChan)
  );

endmodule

// File: rtl/sioCfgGateChk.sv
module sioCfgGateChk #(
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h370,
  parameter int unsigned NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic               busRd,
  input logic [7:0]         busWData,
  input logic [7:0]         busRData,
  input logic               cfgOpen,
  input logic [NUM_DEV-1:0] devActive
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = {BASE_ADDR[ADDR_W-1:1], 1'b0};
  localparam logic [ADDR_W-1:0] DAT_ADDR = {BASE_ADDR[ADDR_W-1:1], 1'b1};

  // R1: opening is always caused by an entry-key byte on the index address
  p_entry_key_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgOpen) |-> $past(busWr && busAddr == IDX_ADDR && busWData == 8'h87));

  // R3: the exit byte locks the gate
  p_exit_locks_r3: assert property (@(posedge clk) disable iff (rst)
    (cfgOpen && busWr && busAddr == IDX_ADDR && busWData == 8'hAA) |=> !cfgOpen);

  // R4: locked reads return all ones
  p_locked_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfgOpen && busRd && (busAddr == IDX_ADDR || busAddr == DAT_ADDR))
      |=> (busRData == 8'hFF));

  // R4: nothing changes device activation while locked
  p_locked_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !cfgOpen |=> $stable(devActive));

endmodule

bind sioCfgGate sioCfgGateChk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .NUM_DEV   (NUM_DEV)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .busWData  (busWData),
  .busRData  (busRData),
  .cfgOpen   (cfgOpen),
  .devActive (devActive)
);

// File: tb/sioCfgGate_tb_top.sv
module sioCfgGate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int NUM_DEV = 4;
  localparam int NUM_BASE = 3;
  localparam logic [ADDR_W-1:0] IDX = 12'h370;
  localparam logic [ADDR_W-1:0] DAT = 12'h371;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic cfgOpen;
  logic [NUM_DEV-1:0] devActive;
  logic [NUM_DEV*NUM_BASE*16-1:0] devBase;
  logic [NUM_DEV*8-1:0] devIrq;
  logic [NUM_DEV*8-1:0] devIrqType;
  logic [NUM_DEV-1:0] devDmaEn;
  logic [NUM_DEV*2-1:0] devDmaChan;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  sioCfgGate #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (12'h370),
    .NUM_DEV   (NUM_DEV),
    .NUM_BASE  (NUM_BASE)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWData   (busWData),
    .busRData   (busRData),
    .cfgOpen    (cfgOpen),
    .devActive  (devActive),
    .devBase    (devBase),
    .devIrq     (devIrq),
    .devIrqType (devIrqType),
    .devDmaEn   (devDmaEn),
    .devDmaChan (devDmaChan)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] d);
    busWrite(IDX, idx);
    busWrite(DAT, d);
  endtask

  // driver: issue a read and push its expected result
  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    it.val = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // monitor: compare registered read data after the sampling edge
  always @(posedge clk) begin
    if (busRd && !rst) begin
      #1;
      if (expQ.size() == 0) begin
        testsRun++; testsFailed++;
        $display("FAIL scoreboard: actual %0h expected none", busRData);
      end else begin
        cur = expQ.pop_front();
        check({24'h0, busRData}, {24'h0, cur.val}, cur.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    check({31'h0, cfgOpen}, 0, "R13 locked after reset");
    check({28'h0, devActive}, 0, "R13 devices inactive");
    check(devIrq, 0, "R13 irq regs zero");

    // R4 locked accesses
    busRead(DAT, 8'hFF, "R4 locked data read");
    busRead(IDX, 8'hFF, "R4 locked index read");
    busWrite(DAT, 8'h55);

    // R2 broken key
    busWrite(IDX, 8'h87);
    busWrite(IDX, 8'h12);
    busWrite(IDX, 8'h87);
    check({31'h0, cfgOpen}, 0, "R2 broken key stays locked");
    busWrite(IDX, 8'hAA);
    check({31'h0, cfgOpen}, 0, "R2 exit byte while locked");

    // R1 proper key
    busWrite(IDX, 8'h87);
    check({31'h0, cfgOpen}, 0, "R1 single key byte");
    busWrite(IDX, 8'h87);
    check({31'h0, cfgOpen}, 1, "R1 gate opens");
    busRead(DAT, 8'h00, "R4 locked write ignored R13 reg zero");

    // R5 R6 shared register
    setReg(8'h22, 8'hFE);
    busRead(DAT, 8'hFE, "R5 read back global");
    busRead(IDX, 8'h22, "R5 index read");

    // device 1 configuration
    setReg(8'h07, 8'h01);
    setReg(8'h30, 8'h01);
    check({28'h0, devActive}, 32'h2, "R8 activate device 1");
    setReg(8'h60, 8'h03);
    setReg(8'h61, 8'h38);
    check(devBase[(1*NUM_BASE+0)*16 +: 16], 32'h0338, "R9 base 0");
    setReg(8'h62, 8'h01);
    setReg(8'h63, 8'h80);
    check(devBase[(1*NUM_BASE+1)*16 +: 16], 32'h0180, "R9 base 1");
    busRead(DAT, 8'h80, "R9 base low byte read");
    setReg(8'h70, 8'h0A);
    setReg(8'h71, 8'h02);
    check(devIrq[15:8], 32'h0A, "R10 irq number");
    check(devIrqType[15:8], 32'h02, "R10 irq type");
    setReg(8'h74, 8'h04);
    check({31'h0, devDmaEn[1]}, 0, "R11 dma none");
    setReg(8'h74, 8'h01);
    check({31'h0, devDmaEn[1]}, 1, "R11 dma enabled");
    check({30'h0, devDmaChan[3:2]}, 1, "R11 dma channel");

    // R7 banking
    setReg(8'h07, 8'h02);
    busWrite(IDX, 8'h30);
    busRead(DAT, 8'h00, "R7 device 2 bank separate");
    busWrite(IDX, 8'h22);
    busRead(DAT, 8'hFE, "R6 global shared across devices");
    setReg(8'h07, 8'h09);
    setReg(8'h30, 8'h01);
    check({28'h0, devActive}, 32'h2, "R7 out of range write ignored");
    busRead(DAT, 8'h00, "R7 out of range read zero");

    // R8 deactivate
    setReg(8'h07, 8'h01);
    setReg(8'h30, 8'h00);
    check({28'h0, devActive}, 0, "R8 deactivate");

    // R12 undefined per-device index
    setReg(8'h40, 8'h77);
    busRead(DAT, 8'h00, "R12 undefined index");

    // R3 exit keeps index, R4 locked write
    busWrite(IDX, 8'h30);
    busWrite(IDX, 8'hAA);
    check({31'h0, cfgOpen}, 0, "R3 exit locks");
    busRead(DAT, 8'hFF, "R4 read after exit");
    busWrite(DAT, 8'h01);
    check({28'h0, devActive}, 0, "R4 locked write no effect");
    busWrite(IDX, 8'h87);
    busWrite(IDX, 8'h87);
    busRead(IDX, 8'h30, "R3 index kept over exit");
    busRead(DAT, 8'h00, "R3 R4 register unchanged");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule